// File: doc/BRIEF.md
# Peripheral Bus Cycle Controller

This block is the master-side cycle generator for a byte-wide peripheral bus. A fast input clock runs at twice the rate the instruction cycle would have against a two-edge oscillator. The block divides that clock into instruction cycles of four quarters each. It drives a master clock strobe that is high in the last quarter, and it raises or lowers the command and bank lines for a whole cycle according to the request it took at the start of that cycle. A request may be an address select, a data write or a data read, and it names one bank, the other bank, or both.

The requester presents a request and holds it. When `reqReady` is high, the request is taken on the clock edge that ends the current cycle. The block also counts completed instruction cycles on a program address output. An active-low reset clears the block and forces the bank lines inactive at once, without waiting for a clock. An active-low halt freezes operation from the next cycle boundary onward. While halted, the master clock keeps running and the bank lines are held inactive from the first quarter.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: An instruction cycle lasts exactly four `clk` periods. `mclk` is high during the fourth period of every cycle and low during the other three, both while running and while halted.
- R2: Requests and `haltN` are sampled only on the rising `clk` edge that ends a cycle, where `reqReady` is high while `haltN` is high. All command, bank, error and halt outputs then stay constant for the whole following cycle, whatever the inputs do in the middle of it.
- R3: An accepted request with `reqSel`=1 and `reqWrite`=0 gives `selCmd`=1 and `wrCmd`=0 for its cycle.
- R4: An accepted request with `reqWrite`=1 and `reqSel`=0 gives `wrCmd`=1 and `selCmd`=0. A read (`reqSel`=0, `reqWrite`=0) gives both low.
- R5: The bank lines are active-low. For an accepted, valid request, `leftBankN` = NOT `reqLeft` and `rightBankN` = NOT `reqRight`, so both may be low in the same cycle.
- R6: A request with both `reqSel` and `reqWrite` high is rejected. For that cycle `errFlag`=1, both commands are 0 and both bank lines are 1. `selCmd` and `wrCmd` are never high together.
- R7: While `rstN` is low, `leftBankN` and `rightBankN` are 1 immediately and without a clock edge, and `mclk`, `selCmd`, `wrCmd` and `progAddr` are 0. The cycle in which `rstN` rises counts as the first quarter of a new cycle, so the first `mclk` pulse comes in its fourth `clk` period.
- R8: `haltN` sampled low at a cycle end makes the next cycle a halted one. `halted`=1, both commands are 0 and both bank lines are 1 from its first quarter, and the request is ignored. `reqReady` stays low at the cycle end while `haltN` is low.
- R9: `progAddr` increases by one at each cycle end that closes a cycle that was not halted. It keeps its value across halted cycles.
- R10: With `reqValid`=0 at a cycle end, the next cycle is idle: both commands are 0, both bank lines are 1 and `errFlag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four periods per instruction cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| haltN | input | 1 | Halt request, active low, sampled at cycle end |
| reqValid | input | 1 | A request is present |
| reqSel | input | 1 | Request is an address select |
| reqWrite | input | 1 | Request is a data write |
| reqLeft | input | 1 | Request uses the left bank |
| reqRight | input | 1 | Request uses the right bank |
| reqReady | output | 1 | High in the last quarter when a request will be taken |
| halted | output | 1 | Current cycle is halted; no bus cycle in progress |
| mclk | output | 1 | Master clock strobe, high in the last quarter |
| selCmd | output | 1 | Address select command |
| wrCmd | output | 1 | Write command |
| leftBankN | output | 1 | Left bank enable, active low |
| rightBankN | output | 1 | Right bank enable, active low |
| errFlag | output | 1 | Current cycle holds a rejected request |
| progAddr | output | ADDR_W | Count of completed non-halted cycles |

## Verification
A phase counter that slips or skips moves the `mclk` pulse off the fourth quarter. It also moves the point where requests are taken, so the very next cycle shows commands one or more clocks early or late. A halt flag latched at the wrong moment shows up within one cycle, either as bank lines going low while `halted` is high or as `progAddr` advancing across a halted cycle. Changing the inputs in mid-cycle exposes command registers that load outside the cycle end, in the same cycle. A wrong reset path shows at once: the bank lines fail to rise before any clock edge arrives.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  // strobes from the cycle control to the bus datapath
  typedef struct packed {
    logic cycleEnd;   // this clock edge closes the current instruction cycle
    logic mclkNext;   // next quarter is the last one
    logic take;       // a request is accepted at this edge
    logic reject;     // the accepted request is illegal
    logic advance;    // the closing cycle was not halted
  } ctrl_strobe_t;
endpackage

// File: rtl/bcc_control.sv
module bcc_control
  import bcc_pkg::*;
#(
  parameter int PHASE_W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         haltN,
  input  logic         reqValid,
  input  logic         reqSel,
  input  logic         reqWrite,
  output ctrl_strobe_t strobe,
  output logic         reqReady,
  output logic         halted
);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'((1 << PHASE_W) - 1);

  logic [PHASE_W-1:0] phaseQ;
  logic               haltQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
      haltQ  <= 1'b0;
    end else begin
      phaseQ <= phaseQ + 1'b1;
      if (phaseQ == LAST_PHASE) haltQ <= !haltN;
    end
  end

  always_comb begin
    strobe.cycleEnd = (phaseQ == LAST_PHASE);
    strobe.mclkNext = (phaseQ == LAST_PHASE - 1'b1);
    strobe.take     = strobe.cycleEnd && haltN && reqValid;
    strobe.reject   = strobe.take && reqSel && reqWrite;
    strobe.advance  = strobe.cycleEnd && !haltQ;
  end

  assign reqReady = strobe.cycleEnd && haltN;
  assign halted   = haltQ;

  // phase advances by exactly one every clock (R1)
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> phaseQ == PHASE_W'($past(phaseQ) + 1'b1));

  // halt state changes only at a cycle boundary (R8)
  assert_halt_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cycleEnd |=> $stable(haltQ));
endmodule

// File: rtl/bcc_datapath.sv
module bcc_datapath
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic              reqSel,
  input  logic              reqWrite,
  input  logic              reqLeft,
  input  logic              reqRight,
  output logic              mclk,
  output logic              selCmd,
  output logic              wrCmd,
  output logic              leftBankN,
  output logic              rightBankN,
  output logic              errFlag,
  output logic [ADDR_W-1:0] progAddr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclk       <= 1'b0;
      selCmd     <= 1'b0;
      wrCmd      <= 1'b0;
      leftBankN  <= 1'b1;
      rightBankN <= 1'b1;
      errFlag    <= 1'b0;
      progAddr   <= '0;
    end else begin
      mclk <= strobe.mclkNext;
      if (strobe.advance) progAddr <= progAddr + 1'b1;
      if (strobe.cycleEnd) begin
        if (strobe.take && !strobe.reject) begin
          selCmd     <= reqSel;
          wrCmd      <= reqWrite;
          leftBankN  <= !reqLeft;
          rightBankN <= !reqRight;
          errFlag    <= 1'b0;
        end else begin
          selCmd     <= 1'b0;
          wrCmd      <= 1'b0;
          leftBankN  <= 1'b1;
          rightBankN <= 1'b1;
          errFlag    <= strobe.reject;
        end
      end
    end
  end

  assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(selCmd && wrCmd));

  assert_reject_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reject |=> errFlag && !selCmd && !wrCmd && leftBankN && rightBankN);

  assert_hold_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cycleEnd |=> $stable({selCmd, wrCmd, leftBankN, rightBankN, errFlag}));

  assert_mclk_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    mclk |=> !mclk);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(progAddr));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int PHASE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltN,
  input  logic              reqValid,
  input  logic              reqSel,
  input  logic              reqWrite,
  input  logic              reqLeft,
  input  logic              reqRight,
  output logic              reqReady,
  output logic              halted,
  output logic              mclk,
  output logic              selCmd,
  output logic              wrCmd,
  output logic              leftBankN,
  output logic              rightBankN,
  output logic              errFlag,
  output logic [ADDR_W-1:0] progAddr
);
  ctrl_strobe_t strobe;

  bcc_control #(.PHASE_W(PHASE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .haltN(haltN), .reqValid(reqValid),
    .reqSel(reqSel), .reqWrite(reqWrite), .strobe(strobe),
    .reqReady(reqReady), .halted(halted)
  );

  bcc_datapath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqSel(reqSel),
    .reqWrite(reqWrite), .reqLeft(reqLeft), .reqRight(reqRight),
    .mclk(mclk), .selCmd(selCmd), .wrCmd(wrCmd), .leftBankN(leftBankN),
    .rightBankN(rightBankN), .errFlag(errFlag), .progAddr(progAddr)
  );
endmodule

// File: tb/bus_cycle_ctrl_test.sv
module bus_cycle_ctrl_test;
  localparam int ADDR_W = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltN = 1'b1;
  logic reqValid = 1'b0, reqSel = 1'b0, reqWrite = 1'b0, reqLeft = 1'b0, reqRight = 1'b0;
  logic reqReady, halted, mclk, selCmd, wrCmd, leftBankN, rightBankN, errFlag;
  logic [ADDR_W-1:0] progAddr;

  int checks = 0;
  int fails = 0;
  logic [ADDR_W-1:0] modelAddr = '0;
  logic prevHalted = 1'b0;

  always #5 clk = ~clk;

  bus_cycle_ctrl #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .haltN(haltN), .reqValid(reqValid), .reqSel(reqSel),
    .reqWrite(reqWrite), .reqLeft(reqLeft), .reqRight(reqRight), .reqReady(reqReady),
    .halted(halted), .mclk(mclk), .selCmd(selCmd), .wrCmd(wrCmd),
    .leftBankN(leftBankN), .rightBankN(rightBankN), .errFlag(errFlag),
    .progAddr(progAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected {selCmd, wrCmd, leftBankN, rightBankN, errFlag, halted}
  function automatic logic [5:0] expBus(input logic v, s, w, l, r, h);
    if (!h) return 6'b001101;
    if (!v) return 6'b001100;
    if (s && w) return 6'b001110;
    return {s, w, !l, !r, 1'b0, 1'b0};
  endfunction

  function automatic string reqTag(input logic v, s, w, h);
    if (!h) return "R8";
    if (!v) return "R10";
    if (s && w) return "R6";
    if (s) return "R3";
    if (w) return "R4";
    return "R5";
  endfunction

  // called at the negedge in the last quarter; runs one full cycle
  task automatic doCycle(input logic v, s, w, l, r, h, input logic scramble);
    logic [5:0] exp;
    string tag;
    reqValid = v; reqSel = s; reqWrite = w; reqLeft = l; reqRight = r; haltN = h;
    #1;
    check("R2 reqReady", {31'b0, reqReady}, {31'b0, h});
    exp = expBus(v, s, w, l, r, h);
    tag = reqTag(v, s, w, h);
    if (!prevHalted) modelAddr = modelAddr + 1'b1;
    prevHalted = !h;
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      if (q == 1 && scramble) begin
        {reqValid, reqSel, reqWrite, reqLeft, reqRight, haltN} = 6'($urandom);
      end
      check("R1 mclk", {31'b0, mclk}, {31'b0, (q == 3)});
      check(q == 3 ? "R2 held" : tag,
            {26'b0, selCmd, wrCmd, leftBankN, rightBankN, errFlag, halted}, {26'b0, exp});
      check("R9 progAddr", {19'b0, progAddr}, {19'b0, modelAddr});
    end
  endtask

  // release reset on a negedge and walk to the last quarter of the first cycle
  task automatic releaseReset();
    @(negedge clk);
    rstN = 1'b1;
    modelAddr = '0;
    prevHalted = 1'b0;
    for (int q = 1; q < 4; q++) begin
      @(negedge clk);
      check("R7 first mclk", {31'b0, mclk}, {31'b0, (q == 3)});
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R7 reset banks", {30'b0, leftBankN, rightBankN}, 32'd3);
    check("R7 reset cmds", {29'b0, mclk, selCmd, wrCmd}, 32'd0);
    check("R7 reset addr", {19'b0, progAddr}, 32'd0);
    releaseReset();

    // directed patterns
    doCycle(1, 0, 0, 1, 1, 1, 0);   // read, both banks (R5)
    doCycle(1, 1, 0, 1, 0, 1, 1);   // select, left bank (R3)
    doCycle(1, 0, 1, 0, 1, 1, 1);   // write, right bank (R4)
    doCycle(1, 1, 1, 1, 1, 1, 0);   // illegal (R6)
    doCycle(0, 1, 0, 1, 1, 1, 1);   // idle (R10)
    doCycle(1, 0, 1, 1, 1, 0, 0);   // halt begins (R8)
    doCycle(1, 1, 0, 1, 1, 0, 1);   // still halted, request ignored (R8)
    doCycle(1, 0, 0, 0, 1, 1, 0);   // resume

    // asynchronous reset in mid-cycle with banks low (R7)
    doCycle(1, 0, 0, 1, 1, 1, 0);
    @(negedge clk);
    #2 rstN = 1'b0;
    #1;
    check("R7 async banks", {30'b0, leftBankN, rightBankN}, 32'd3);
    check("R7 async mclk/addr", {18'b0, mclk, progAddr}, 32'd0);
    @(negedge clk);
    releaseReset();

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] rnd;
      rnd = 8'($urandom);
      doCycle(rnd[0] | rnd[1], rnd[2], rnd[3], rnd[4], rnd[5],
              (($urandom % 8) != 0), rnd[6]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule